// File: doc/BRIEF.md
# Quadrature Position and Revolution Counter

This block tracks an incremental shaft encoder. Two phase inputs, A and B, are decoded into a 16-bit position count, and an index input, pulsed once per turn, steps a 16-bit revolution count and returns the position to zero. In a second mode the two phase inputs act as separate count-up and count-down strobes. Each of the three inputs has its own selectable active edge. Every input passes through a two-stage synchroniser before its edges are detected.

Two compare values are held in registers, one against the position and one against the revolution count. A count update that lands on a compare value sets a sticky status bit, and that bit drives the interrupt output when its enable is set. Software reaches everything through a plain write port and a combinational read port. Neither port has back-pressure: a write is taken on every clock edge where the write enable is high, and read data follows the read address within the same cycle. The encoder inputs have no handshake either, since they are sampled levels and not a data stream.

Top module: `qpr_counter`

## Requirements
- R1: After reset, position, revolution, control, both compare values and both status flags are zero, the stored direction is up (status bit 2 = 1), and irq_o is low.
- R2: A change on a phase input changes the position readback at the third rising clock edge after it, and not earlier.
- R3: In quadrature mode (control bits [1:0] = 01), a selected A edge counts up when the new A level differs from B and down otherwise. A selected B edge counts up when the new B level equals A and down otherwise.
- R4: Each edge-select field (A in control [3:2], B in [5:4], index in [7:6]) encodes 00 = no edge, 01 = rising, 10 = falling, 11 = both. An edge that is not selected changes nothing.
- R5: In quadrature mode, if A and B both change in the same cycle, the position does not change.
- R6: In up/down mode (control [1:0] = 10), a selected A edge adds one, a selected B edge subtracts one, and both in one cycle leave the position unchanged.
- R7: A selected index edge sets the position to zero and moves the revolution count by +1 if the stored direction is up and by -1 if it is down. A phase step in the same cycle is discarded.
- R8: In hold mode (control [1:0] = 00 or 11), phase and index edges leave position and revolution unchanged.
- R9: Position and revolution wrap modulo 2^16 in both directions.
- R10: Status bit 0 is set when a count or index update gives the position the value of the position compare register (address 3). Status bit 1 is set when an index update gives the revolution the value of the revolution compare register (address 4). Both bits stay set until a 1 is written to them at address 5. Register writes never set them.
- R11: irq_o is high exactly when (status bit 0 and control bit 8) or (status bit 1 and control bit 9).
- R12: A write to address 1 (position) or address 2 (revolution) loads that counter at the next clock edge. It takes priority over counting and index in that cycle. Address 0 holds control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enc_a_i | input | 1 | Encoder phase A (asynchronous) |
| enc_b_i | input | 1 | Encoder phase B (asynchronous) |
| enc_idx_i | input | 1 | Encoder index (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Compare interrupt |

## Verification
An index edge and a phase step can arrive in the same cycle. The bench provokes this by changing B and raising the index at the same clock edge, with the stored direction known to be up. It then reads back a position of zero and a revolution count one higher, which shows that the index won and the step was discarded. A compare hit can also fall in the same cycle as the index clearing. In the bench, an index update lands the revolution on its compare value, and the bench confirms that only status bit 1 and the interrupt rise.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_QUAD = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_RSVD = 2'b11
  } qpr_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } qpr_edge_e;

  // control register layout, LSB last
  typedef struct packed {
    logic      ie_rev;
    logic      ie_pos;
    qpr_edge_e idx_edge;
    qpr_edge_e b_edge;
    qpr_edge_e a_edge;
    qpr_mode_e mode;
  } qpr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(qpr_ctrl_t);
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_POS     = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_REV     = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMP_POS = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CMP_REV = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd5;

  function automatic logic edge_hit(qpr_edge_e sel, logic rise, logic fall);
    logic hit;
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/qpr_edge_sync.sv
module qpr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-1:0], pin_i};
  end

  assign lvl_o  = shift_q[STAGES-1];
  assign rise_o =  shift_q[STAGES-1] & ~shift_q[STAGES];
  assign fall_o = ~shift_q[STAGES-1] &  shift_q[STAGES];

endmodule

// File: rtl/qpr_decode.sv
module qpr_decode
  import qpr_pkg::*;
(
  input  qpr_ctrl_t  ctrl_i,
  input  logic [2:0] lvl_i,   // {idx, b, a}
  input  logic [2:0] rise_i,
  input  logic [2:0] fall_i,
  output logic       step_up_o,
  output logic       step_dn_o,
  output logic       idx_evt_o
);

  logic a_hit, b_hit, i_hit, a_chg, b_chg;

  always_comb begin
    a_hit = edge_hit(ctrl_i.a_edge,   rise_i[0], fall_i[0]);
    b_hit = edge_hit(ctrl_i.b_edge,   rise_i[1], fall_i[1]);
    i_hit = edge_hit(ctrl_i.idx_edge, rise_i[2], fall_i[2]);
    a_chg = rise_i[0] | fall_i[0];
    b_chg = rise_i[1] | fall_i[1];

    step_up_o = 1'b0;
    step_dn_o = 1'b0;
    idx_evt_o = 1'b0;

    unique case (ctrl_i.mode)
      MODE_QUAD: begin
        idx_evt_o = i_hit;
        if (a_hit && !b_chg) begin
          step_up_o = (lvl_i[0] != lvl_i[1]);
          step_dn_o = (lvl_i[0] == lvl_i[1]);
        end else if (b_hit && !a_chg) begin
          step_up_o = (lvl_i[1] == lvl_i[0]);
          step_dn_o = (lvl_i[1] != lvl_i[0]);
        end
      end
      MODE_UPDN: begin
        idx_evt_o = i_hit;
        step_up_o = a_hit && !b_hit;
        step_dn_o = b_hit && !a_hit;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/qpr_counters.sv
module qpr_counters #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_up_i,
  input  logic             step_dn_i,
  input  logic             idx_evt_i,
  input  logic             pos_ld_i,
  input  logic             rev_ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] cmp_pos_i,
  input  logic [CNT_W-1:0] cmp_rev_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] rev_o,
  output logic             dir_up_o,
  output logic             pos_hit_o,
  output logic             rev_hit_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pos_q, rev_q, pos_nxt, rev_nxt;
  logic             dir_q, pos_upd;

  always_comb begin
    pos_nxt = pos_q;
    pos_upd = 1'b0;
    if (idx_evt_i) begin
      pos_nxt = '0;
      pos_upd = 1'b1;
    end else if (step_up_i) begin
      pos_nxt = pos_q + ONE;
      pos_upd = 1'b1;
    end else if (step_dn_i) begin
      pos_nxt = pos_q - ONE;
      pos_upd = 1'b1;
    end
    rev_nxt = dir_q ? rev_q + ONE : rev_q - ONE;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pos_q <= '0;
      rev_q <= '0;
      dir_q <= 1'b1;
    end else begin
      if (pos_ld_i)     pos_q <= ld_val_i;
      else if (pos_upd) pos_q <= pos_nxt;

      if (rev_ld_i)       rev_q <= ld_val_i;
      else if (idx_evt_i) rev_q <= rev_nxt;

      if (step_up_i)      dir_q <= 1'b1;
      else if (step_dn_i) dir_q <= 1'b0;
    end
  end

  assign pos_hit_o = !pos_ld_i && pos_upd   && (pos_nxt == cmp_pos_i);
  assign rev_hit_o = !rev_ld_i && idx_evt_i && (rev_nxt == cmp_rev_i);
  assign pos_o     = pos_q;
  assign rev_o     = rev_q;
  assign dir_up_o  = dir_q;

endmodule

// File: rtl/qpr_regs.sv
module qpr_regs
  import qpr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic [CNT_W-1:0]  pos_i,
  input  logic [CNT_W-1:0]  rev_i,
  input  logic              dir_up_i,
  input  logic              pos_hit_i,
  input  logic              rev_hit_i,
  output qpr_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  cmp_pos_o,
  output logic [CNT_W-1:0]  cmp_rev_o,
  output logic              pos_ld_o,
  output logic              rev_ld_o,
  output logic [1:0]        flags_o,
  output logic              irq_o
);

  qpr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cmp_pos_q, cmp_rev_q;
  logic [1:0]       flag_q, clr;

  assign pos_ld_o = wr_en_i && (wr_addr_i == ADR_POS);
  assign rev_ld_o = wr_en_i && (wr_addr_i == ADR_REV);
  assign clr      = (wr_en_i && (wr_addr_i == ADR_STAT)) ? wr_data_i[1:0] : 2'b00;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      cmp_pos_q <= '0;
      cmp_rev_q <= '0;
      flag_q    <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == ADR_CTRL)    ctrl_q    <= qpr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_en_i && wr_addr_i == ADR_CMP_POS) cmp_pos_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == ADR_CMP_REV) cmp_rev_q <= wr_data_i;
      // a new hit wins over a clear in the same cycle
      flag_q <= {rev_hit_i, pos_hit_i} | (flag_q & ~clr);
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADR_CTRL:    rd_data_o = CNT_W'(ctrl_q);
      ADR_POS:     rd_data_o = pos_i;
      ADR_REV:     rd_data_o = rev_i;
      ADR_CMP_POS: rd_data_o = cmp_pos_q;
      ADR_CMP_REV: rd_data_o = cmp_rev_q;
      ADR_STAT:    rd_data_o = CNT_W'({dir_up_i, flag_q});
      default:     rd_data_o = '0;
    endcase
  end

  assign irq_o     = (flag_q[0] & ctrl_q.ie_pos) | (flag_q[1] & ctrl_q.ie_rev);
  assign ctrl_o    = ctrl_q;
  assign cmp_pos_o = cmp_pos_q;
  assign cmp_rev_o = cmp_rev_q;
  assign flags_o   = flag_q;

endmodule

// File: rtl/qpr_counter.sv
module qpr_counter
  import qpr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              enc_idx_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              irq_o
);

  localparam int unsigned N_IN = 3;

  logic [N_IN-1:0]  pins, lvl, rise, fall;
  qpr_ctrl_t        ctrl;
  logic             step_up, step_dn, idx_evt, pos_ld, rev_ld;
  logic             dir_up, pos_hit, rev_hit;
  logic [CNT_W-1:0] pos_q, rev_q, cmp_pos, cmp_rev;
  logic [1:0]       flags;

  assign pins = {enc_idx_i, enc_b_i, enc_a_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    qpr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .lvl_o  (lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  qpr_decode u_decode (
    .ctrl_i    (ctrl),
    .lvl_i     (lvl),
    .rise_i    (rise),
    .fall_i    (fall),
    .step_up_o (step_up),
    .step_dn_o (step_dn),
    .idx_evt_o (idx_evt)
  );

  qpr_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_up_i (step_up),
    .step_dn_i (step_dn),
    .idx_evt_i (idx_evt),
    .pos_ld_i  (pos_ld),
    .rev_ld_i  (rev_ld),
    .ld_val_i  (wr_data_i),
    .cmp_pos_i (cmp_pos),
    .cmp_rev_i (cmp_rev),
    .pos_o     (pos_q),
    .rev_o     (rev_q),
    .dir_up_o  (dir_up),
    .pos_hit_o (pos_hit),
    .rev_hit_o (rev_hit)
  );

  qpr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .pos_i     (pos_q),
    .rev_i     (rev_q),
    .dir_up_i  (dir_up),
    .pos_hit_i (pos_hit),
    .rev_hit_i (rev_hit),
    .ctrl_o    (ctrl),
    .cmp_pos_o (cmp_pos),
    .cmp_rev_o (cmp_rev),
    .pos_ld_o  (pos_ld),
    .rev_ld_o  (rev_ld),
    .flags_o   (flags),
    .irq_o     (irq_o)
  );

endmodule

// File: rtl/qpr_counter_chk.sv
module qpr_counter_chk
  import qpr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic              idx_evt,
  input logic              pos_ld,
  input logic              rev_ld,
  input qpr_mode_e         mode,
  input logic [CNT_W-1:0]  pos_q,
  input logic [CNT_W-1:0]  rev_q,
  input logic [1:0]        flags,
  input logic              irq_o
);

  logic clr_pos_flag;
  assign clr_pos_flag = wr_en_i && (wr_addr_i == ADR_STAT) && wr_data_i[0];

  // R7
  idx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_evt && !pos_ld) |=> (pos_q == '0));

  // R7
  rev_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_evt && !rev_ld) |=> $stable(rev_q));

  // R12
  load_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_ld |=> (pos_q == $past(wr_data_i)));

  // R8
  hold_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HOLD && !pos_ld) |=> $stable(pos_q));

  // R9
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pos_ld && !idx_evt) |=> (pos_q == $past(pos_q)
                               || pos_q == CNT_W'($past(pos_q) + CNT_W'(1))
                               || pos_q == CNT_W'($past(pos_q) - CNT_W'(1))));

  // R10
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[0] && !clr_pos_flag) |=> flags[0]);

  // R11
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != 2'b00));

endmodule

bind qpr_counter qpr_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .idx_evt   (idx_evt),
  .pos_ld    (pos_ld),
  .rev_ld    (rev_ld),
  .mode      (ctrl.mode),
  .pos_q     (pos_q),
  .rev_q     (rev_q),
  .flags     (flags),
  .irq_o     (irq_o)
);

// File: tb/test_qpr_counter.sv
module test_qpr_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a = 1'b0, b = 1'b0, idx = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  qpr_counter i_qpr_counter (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .enc_a_i   (a),
    .enc_b_i   (b),
    .enc_idx_i (idx),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  // {a, b, idx, expected position, expected revolution}, control = 0x7D
  localparam logic [34:0] VEC [16] = '{
    {3'b100, 16'h0001, 16'h0000},  // R3 A rise, B low: up
    {3'b110, 16'h0002, 16'h0000},  // R3 B rise, equal: up
    {3'b010, 16'h0003, 16'h0000},
    {3'b000, 16'h0004, 16'h0000},
    {3'b010, 16'h0003, 16'h0000},  // R3 reverse: down
    {3'b110, 16'h0002, 16'h0000},
    {3'b100, 16'h0001, 16'h0000},
    {3'b000, 16'h0000, 16'h0000},
    {3'b010, 16'hFFFF, 16'h0000},  // R9 wrap below zero
    {3'b011, 16'h0000, 16'hFFFF},  // R7 index while down
    {3'b010, 16'h0000, 16'hFFFF},  // R4 index fall not selected
    {3'b110, 16'hFFFF, 16'hFFFF},
    {3'b100, 16'hFFFE, 16'hFFFF},
    {3'b110, 16'hFFFF, 16'hFFFF},  // up again
    {3'b111, 16'h0000, 16'h0000},  // R7 index while up, R9 rev wrap
    {3'b000, 16'h0000, 16'h0000}   // R5 A and B together
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] ad, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] ad, output logic [15:0] v);
    rd_addr = ad;
    #0.5;
    v = rd_data;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_pr(string req, logic [15:0] ep, logic [15:0] er);
    logic [15:0] v;
    rd(3'd1, v); chk(req, v, ep);
    rd(3'd2, v); chk(req, v, er);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    expect_pr("R1 counters", 16'h0000, 16'h0000);
    rd(3'd3, v); chk("R1 cmp_pos", v, 16'h0000);
    rd(3'd5, v); chk("R1 status", v, 16'h0004);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    wr(3'd0, 16'h007D);
    for (int i = 0; i < 16; i++) begin
      {a, b, idx} = VEC[i][34:32];
      settle();
      expect_pr("R3 table", VEC[i][31:16], VEC[i][15:0]);
    end

    // R2 latency
    a = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd1, v); chk("R2 early", v, 16'h0000);
    @(negedge clk);
    rd(3'd1, v); chk("R2 on time", v, 16'h0001);

    // R7 index and phase step in the same cycle
    b = 1'b1; idx = 1'b1;
    settle();
    expect_pr("R7 collision", 16'h0000, 16'h0001);
    idx = 1'b0; settle();

    // R12 software loads
    wr(3'd1, 16'h1234);
    wr(3'd2, 16'h0010);
    expect_pr("R12 load", 16'h1234, 16'h0010);

    // R10 / R11 position compare
    wr(3'd3, 16'h1236);
    wr(3'd5, 16'h0003);
    wr(3'd0, 16'h017D);
    a = 1'b0; settle();
    rd(3'd5, v); chk("R10 no hit yet", v, 16'h0004);
    chk("R11 irq low", {15'd0, irq}, 16'h0000);
    b = 1'b0; settle();
    rd(3'd5, v); chk("R10 pos hit", v, 16'h0005);
    chk("R11 irq high", {15'd0, irq}, 16'h0001);
    b = 1'b1; settle();
    rd(3'd5, v); chk("R10 sticky", v, 16'h0001);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); chk("R10 cleared", v, 16'h0000);
    chk("R11 irq cleared", {15'd0, irq}, 16'h0000);

    // R10 / R11 revolution compare with index
    wr(3'd4, 16'h000F);
    wr(3'd0, 16'h037D);
    idx = 1'b1; settle();
    expect_pr("R7 index down", 16'h0000, 16'h000F);
    rd(3'd5, v); chk("R10 rev hit", v, 16'h0002);
    chk("R11 rev irq", {15'd0, irq}, 16'h0001);
    wr(3'd5, 16'h0002);
    chk("R11 rev irq cleared", {15'd0, irq}, 16'h0000);
    idx = 1'b0; settle();

    // R4 edge selection: A rise only, B and index none
    wr(3'd0, 16'h0005);
    a = 1'b1; settle();
    expect_pr("R4 A rise", 16'hFFFF, 16'h000F);
    a = 1'b0; settle();
    rd(3'd1, v); chk("R4 A fall ignored", v, 16'hFFFF);
    b = 1'b0; settle();
    rd(3'd1, v); chk("R4 B ignored", v, 16'hFFFF);
    idx = 1'b1; settle(); idx = 1'b0; settle();
    expect_pr("R4 index ignored", 16'hFFFF, 16'h000F);

    // R6 up/down mode, rising edges selected
    wr(3'd0, 16'h0016);
    wr(3'd1, 16'hFFFF);
    a = 1'b1; settle();
    rd(3'd1, v); chk("R9 wrap up", v, 16'h0000);
    b = 1'b1; settle();
    rd(3'd1, v); chk("R6 B down", v, 16'hFFFF);
    a = 1'b0; b = 1'b0; settle();
    rd(3'd1, v); chk("R6 falls ignored", v, 16'hFFFF);
    a = 1'b1; b = 1'b1; settle();
    rd(3'd1, v); chk("R6 both cancel", v, 16'hFFFF);

    // R8 hold mode
    wr(3'd0, 16'h007C);
    a = 1'b0; b = 1'b0; idx = 1'b1; settle();
    expect_pr("R8 hold", 16'hFFFF, 16'h000F);
    idx = 1'b0; settle();

    // R5 simultaneous phase change in quadrature mode
    wr(3'd0, 16'h007D);
    a = 1'b1; b = 1'b1; settle();
    rd(3'd1, v); chk("R5 both change", v, 16'hFFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule